// File: doc/BRIEF.md
# Paired Transmit/Receive Word Queues

This block holds the two word queues that sit between a register interface and a serial bus engine. One queue carries outgoing words: the register side pushes them and the engine pops them. The other carries incoming words: the engine pushes them and the register side pops them. Each queue is eight entries of 9-bit words, written so that the storage can map onto block RAM.

Occupancy is reported through a 3-bit level field. An eight-entry queue cannot show a count of eight in three bits, so the field wraps: a full queue reads level 0. Full and empty are told apart by separate flags. The outgoing queue has a full flag, a half-full flag and a not-empty flag for the engine. The incoming queue has a ready flag, set while it holds any word, and a half-full flag. A soft clear input empties both queues at once.

Top module: `word_queue_pair`

## Requirements
- R1: Each queue stores up to eight 9-bit words and returns them in the order they were pushed.
- R2: The 3-bit level output equals the number of stored words modulo 8, so a queue holding eight words reads level 0.
- R3: A push to a queue that already holds eight words is dropped: level, flags and stored contents stay as they were.
- R4: A pop from an empty queue loads zero into that queue's read-data output and leaves level and flags unchanged.
- R5: The outgoing full flag is 1 exactly when the outgoing queue holds eight words.
- R6: Each half-full flag is 1 exactly when its queue holds four or more words.
- R7: The outgoing not-empty flag and the incoming ready flag are 1 exactly when their queue holds one or more words. This tells a full queue (level 0, flag 1) apart from an empty one (level 0, flag 0).
- R8: A soft clear empties both queues and zeroes both read-data outputs on the next clock edge. It takes priority over any push or pop in the same cycle.
- R9: Level and flags change on the clock edge that accepts a push or pop. A popped word appears on read data after that same edge and holds until the next pop or clear.
- R10: When a push and a pop reach one queue in the same cycle, each is judged against the occupancy before the edge. On a full queue the pop is taken and the push dropped, leaving seven words. On an empty queue the push is taken and the pop returns zero, leaving one word.
- R11: After synchronous reset both queues are empty, and all levels, flags and read data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Empties both queues |
| tx_push | input | 1 | Push a word into the outgoing queue (register side) |
| tx_wdata | input | 9 | Word pushed into the outgoing queue |
| tx_pop | input | 1 | Pop from the outgoing queue (engine side) |
| tx_rdata | output | 9 | Last word popped from the outgoing queue |
| tx_level | output | 3 | Outgoing occupancy modulo 8 |
| tx_full | output | 1 | Outgoing queue holds eight words |
| tx_half | output | 1 | Outgoing queue holds four or more words |
| tx_avail | output | 1 | Outgoing queue holds at least one word |
| rx_push | input | 1 | Push a word into the incoming queue (engine side) |
| rx_wdata | input | 9 | Word pushed into the incoming queue |
| rx_pop | input | 1 | Pop from the incoming queue (register side) |
| rx_rdata | output | 9 | Last word popped from the incoming queue |
| rx_level | output | 3 | Incoming occupancy modulo 8 |
| rx_ready | output | 1 | Incoming queue holds at least one word |
| rx_half | output | 1 | Incoming queue holds four or more words |

## Verification
Directed sequences fill the outgoing queue to eight and then push once more. This separates the wrapped level of a full queue from an empty one and shows that the extra word never comes out. Pops on empty queues, simultaneous push and pop at both the empty and the full boundary, and a soft clear issued together with a push show whether each request is judged against the occupancy before the edge and whether the clear wins. A long run of seeded random pushes, pops and rare clears on both queues at once is then compared with a bench model. This exposes crosstalk between the queues, pointer wrap errors and read-data ordering faults that the directed cases do not reach.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int unsigned DEF_WIDTH = 9;
  localparam int unsigned DEF_DEPTH = 8;

  // occupancy at which the half-full flag switches on
  function automatic int unsigned half_mark(input int unsigned depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/wq_store.sv
module wq_store #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re_ok,
  input  logic             re_req,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // write port: no reset so the array can map onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst || clr)  rdata_q <= '0;
    else if (re_ok)  rdata_q <= mem[raddr];
    else if (re_req) rdata_q <= '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wq_ctrl.sv
module wq_ctrl
  import wq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = half_mark(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] level,
  output logic          half,
  output logic          nonempty
);
  logic [CNT_W-1:0] count_q, count_n;
  logic [AW-1:0]    wptr_q, rptr_q, level_q;
  logic             full_q, half_q, ne_q;

  // requests are judged against the occupancy before the edge
  assign push_ok = push & ~full_q & ~clr;
  assign pop_ok  = pop  &  ne_q   & ~clr;
  assign count_n = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      ne_q    <= 1'b0;
    end else begin
      count_q <= count_n;
      if (push_ok) wptr_q <= wptr_q + AW'(1);
      if (pop_ok)  rptr_q <= rptr_q + AW'(1);
      level_q <= count_n[AW-1:0];
      full_q  <= (count_n == CNT_W'(DEPTH));
      half_q  <= (count_n >= CNT_W'(HALF));
      ne_q    <= (count_n != '0);
    end
  end

  assign wptr     = wptr_q;
  assign rptr     = rptr_q;
  assign level    = level_q;
  assign half     = half_q;
  assign nonempty = ne_q;
endmodule

// File: rtl/wq_lane.sv
module wq_lane #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [AW-1:0]    level,
  output logic             half,
  output logic             nonempty
);
  logic          push_ok, pop_ok;
  logic [AW-1:0] wptr, rptr;

  wq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .wptr(wptr), .rptr(rptr),
    .level(level), .half(half), .nonempty(nonempty)
  );

  wq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .we(push_ok), .waddr(wptr),
    .wdata(wdata), .re_ok(pop_ok), .re_req(pop & ~clr), .raddr(rptr),
    .rdata(rdata)
  );
endmodule

// File: rtl/word_queue_pair.sv
module word_queue_pair
  import wq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH),
  localparam int unsigned NQ    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_full,
  output logic             tx_half,
  output logic             tx_avail,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_ready,
  output logic             rx_half
);
  // lane 0 = outgoing, lane 1 = incoming
  logic [NQ-1:0]    push_v, pop_v, half_v, ne_v;
  logic [WIDTH-1:0] wdata_v [NQ];
  logic [WIDTH-1:0] rdata_v [NQ];
  logic [LVL_W-1:0] level_v [NQ];

  assign push_v     = {rx_push, tx_push};
  assign pop_v      = {rx_pop, tx_pop};
  assign wdata_v[0] = tx_wdata;
  assign wdata_v[1] = rx_wdata;

  for (genvar g = 0; g < NQ; g++) begin : g_lane
    wq_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst(rst), .clr(soft_clr),
      .push(push_v[g]), .wdata(wdata_v[g]), .pop(pop_v[g]),
      .rdata(rdata_v[g]), .level(level_v[g]),
      .half(half_v[g]), .nonempty(ne_v[g])
    );
  end

  assign tx_rdata = rdata_v[0];
  assign tx_level = level_v[0];
  assign tx_half  = half_v[0];
  assign tx_avail = ne_v[0];
  // wrapped level 0 with words present means all entries are taken
  assign tx_full  = ne_v[0] & (level_v[0] == '0);

  assign rx_rdata = rdata_v[1];
  assign rx_level = level_v[1];
  assign rx_half  = half_v[1];
  assign rx_ready = ne_v[1];
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_clr,
  input logic             tx_push,
  input logic [WIDTH-1:0] tx_wdata,
  input logic             tx_pop,
  input logic [WIDTH-1:0] tx_rdata,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_full,
  input logic             tx_half,
  input logic             tx_avail,
  input logic             rx_push,
  input logic [WIDTH-1:0] rx_wdata,
  input logic             rx_pop,
  input logic [WIDTH-1:0] rx_rdata,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_ready,
  input logic             rx_half
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_push && !tx_pop && !soft_clr) |=> (tx_full && $stable(tx_level)));

  assert_empty_pop_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && rx_pop && !rx_push && !soft_clr) |=> (rx_rdata == '0 && !rx_ready));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (!tx_avail && !rx_ready && tx_level == '0 && rx_level == '0
                  && tx_rdata == '0 && rx_rdata == '0));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && tx_push && !tx_full && !tx_pop)
      |=> (tx_avail && tx_level == LVL_W'($past(tx_level) + 1'b1)));

  assert_half_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_half |-> rx_ready));

  assert_full_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && tx_full && tx_push && tx_pop)
      |=> (!tx_full && tx_level == LVL_W'(DEPTH - 1)));
endmodule

bind word_queue_pair wq_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_word_queue_pair.sv
`timescale 1ns/1ps
module sim_word_queue_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_clr = 1'b0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [8:0] tx_wdata = '0, rx_wdata = '0;
  logic [8:0] tx_rdata, rx_rdata;
  logic [2:0] tx_level, rx_level;
  logic       tx_full, tx_half, tx_avail, rx_ready, rx_half;

  int    errors = 0;
  int    checks = 0;
  string ctx = "R11 reset";
  int    txq[$];
  int    rxq[$];
  logic [8:0] exp_tx_d = '0, exp_rx_d = '0;

  always #2.5 clk = ~clk;

  word_queue_pair u0 (
    .clk(clk), .rst(rst), .soft_clr(soft_clr),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_full(tx_full),
    .tx_half(tx_half), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_ready(rx_ready),
    .rx_half(rx_half)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s act=%0d exp=%0d", ctx, what, act, exp);
    end
  endtask

  // model of one queue: pop and push both judged on pre-edge occupancy
  task automatic model(ref int q[$], ref logic [8:0] d, input bit push,
                       input logic [8:0] wd, input bit pop, input bit clr);
    bit full0, emp0;
    if (clr) begin
      q.delete();
      d = '0;
    end else begin
      full0 = (q.size() == 8);
      emp0  = (q.size() == 0);
      if (pop) d = emp0 ? 9'd0 : 9'(q.pop_front());
      if (push && !full0) q.push_back(int'(wd));
    end
  endtask

  task automatic check_all();
    int nt = txq.size();
    int nr = rxq.size();
    chk(tx_level == 3'(nt % 8), "R2 tx level", tx_level, nt % 8);
    chk(tx_full == (nt == 8), "R5 tx full", tx_full, nt == 8);
    chk(tx_half == (nt >= 4), "R6 tx half", tx_half, nt >= 4);
    chk(tx_avail == (nt > 0), "R7 tx avail", tx_avail, nt > 0);
    chk(tx_rdata == exp_tx_d, "R1 tx data", tx_rdata, exp_tx_d);
    chk(rx_level == 3'(nr % 8), "R2 rx level", rx_level, nr % 8);
    chk(rx_half == (nr >= 4), "R6 rx half", rx_half, nr >= 4);
    chk(rx_ready == (nr > 0), "R7 rx ready", rx_ready, nr > 0);
    chk(rx_rdata == exp_rx_d, "R1 rx data", rx_rdata, exp_rx_d);
  endtask

  // drive at the falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input bit tp, input logic [8:0] td, input bit tq,
                      input bit rp, input logic [8:0] rd, input bit rq,
                      input bit clr);
    tx_push = tp; tx_wdata = td; tx_pop = tq;
    rx_push = rp; rx_wdata = rd; rx_pop = rq;
    soft_clr = clr;
    @(posedge clk);
    model(txq, exp_tx_d, tp, td, tq, clr);
    model(rxq, exp_rx_d, rp, rd, rq, clr);
    @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; soft_clr = 0;
    check_all();
  endtask

  initial begin
    int seed_set;
    seed_set = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    ctx = "R11 reset";
    check_all();

    ctx = "R2 R5 fill";
    for (int i = 0; i < 8; i++) step(1, 9'(9'h100 + i * 3), 0, 0, 0, 0, 0);
    ctx = "R3 overflow";
    step(1, 9'h1AA, 0, 0, 0, 0, 0);
    ctx = "R1 R9 drain";
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0, 0);
    ctx = "R4 empty pop";
    step(0, 0, 1, 0, 0, 1, 0);

    ctx = "R10 full push+pop";
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 9'(i + 40), 0, 0);
    step(0, 0, 0, 1, 9'h0FF, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    ctx = "R10 empty push+pop";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0);
    step(1, 9'h155, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);

    ctx = "R8 clear";
    for (int i = 0; i < 5; i++) step(1, 9'(i), 0, 1, 9'(i + 7), 0, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    step(1, 9'h077, 1, 1, 9'h066, 1, 1);
    step(0, 0, 1, 0, 0, 1, 0);

    ctx = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 55, 9'($urandom), ($urandom % 100) < 45,
           ($urandom % 100) < 50, 9'($urandom), ($urandom % 100) < 50,
           ($urandom % 200) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL [watchdog] run did not finish act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule